// File: doc/BRIEF.md
# Accumulator ALU with Condition Codes

This block is the arithmetic and logic unit of a small two-accumulator processor. Each cycle it takes two operands, an operation code and the present condition code byte. From these it produces the data result and the next condition code byte. The block is purely combinational. The surrounding core picks the operands, decides whether to write the result back, and latches the returned condition codes.

Each operation has its own rule for every flag. A flag is either computed from the operation, left as it was, forced to 0 or forced to 1. A small decoder turns the operation code into a result source and one action per flag. Separate units for add/subtract and for shift/rotate feed a common flag merger.

The condition byte has a fixed layout that the rest of the core decodes:

| Bit | Meaning |
|-----|---------|
| 5 | half carry H |
| 4 | interrupt mask I |
| 3 | negative N |
| 2 | zero Z |
| 1 | overflow V |
| 0 | carry C |

Bits 7 and 6 always read as 1.

Top module: `acc_alu`

## Requirements
- R1: In `cc_out`, bits 7 and 6 are always 1, and bit 4 (interrupt mask) always equals `cc_in` bit 4, for every op code.
- R2: Add (op 0) gives a+b and add-with-carry (op 1) gives a+b+C. Both set H to the carry out of bit 3 and C to the carry out of bit 7. V is set when both operands share a sign and the result's sign differs. N and Z are taken from the result.
- R3: Subtract (op 2) gives a-b and subtract-with-carry (op 3) gives a-b-C. Compare (op 4) computes the same flags as subtract but returns `opnd_a` unchanged. For all three, C is the borrow and V is set when the operand signs differ and the result's sign differs from a. H is left unchanged.
- R4: AND (op 5), OR (op 6) and XOR (op 7) return the bitwise result. Bit test (op 8) takes its flags from a AND b but returns `opnd_a`. Pass (op 9) returns `opnd_b`. All five set N and Z from that value, force V to 0, and leave H and C unchanged.
- R5: Clear (op 14) returns 0 and forces N=0, Z=1, V=0 and C=0. H is left unchanged.
- R6: Complement (op 10) returns ~a with V=0 and C=1. Negate (op 11) returns 0-a, sets C when a is nonzero, and sets V when a is 0x80. Both take N and Z from the result.
- R7: Increment (op 12) and decrement (op 13) set N and Z from the result. V is set only for 0x7F→0x80 (increment) and 0x80→0x7F (decrement). C is left unchanged.
- R8: Test (op 15) returns `opnd_a`, sets N and Z from it, and forces V=0 and C=0.
- R9: Arithmetic shift left (op 16) moves bit 7 into C. Arithmetic shift right (op 17) keeps bit 7 and moves bit 0 into C. For both, N and Z come from the result and V = N xor C.
- R10: Logical shift right (op 18) shifts a 0 into bit 7 and moves bit 0 into C. It forces N=0, so V equals the new C.
- R11: Rotate left (op 19) puts the old C into bit 0 and moves bit 7 into C. Rotate right (op 20) puts the old C into bit 7 and moves bit 0 into C. For both, N and Z come from the result and V = N xor C.
- R12: Op codes 21 to 31 have no effect. `result` equals `opnd_a`, and `cc_out` bits 5..0 equal `cc_in` bits 5..0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | first operand (the accumulator) |
| opnd_b | input | WIDTH | second operand |
| op_sel | input | 5 | operation code, values as in the requirements |
| cc_in | input | 8 | present condition code byte |
| result | output | WIDTH | data result |
| cc_out | output | 8 | next condition code byte |

## Verification
The bench builds the block with its default WIDTH of 8. At that width the half carry comes from bit 3 and the sign from bit 7, exactly as the condition byte layout assumes, so every flag rule can be checked against hand-worked values. The edge operands 0x00, 0x7F, 0x80 and 0xFF reach every overflow, borrow and zero case. A sweep over all 32 op codes, with the interrupt mask both set and clear, also covers the reserved codes and the mask pass-through.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int OP_W = 5;
    localparam int CC_W = 8;

    // condition code bit positions (decoded by the core)
    localparam int CC_C = 0;
    localparam int CC_V = 1;
    localparam int CC_Z = 2;
    localparam int CC_N = 3;
    localparam int CC_I = 4;
    localparam int CC_H = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_CMP  = 5'd4,
        OP_AND  = 5'd5,
        OP_OR   = 5'd6,
        OP_XOR  = 5'd7,
        OP_BIT  = 5'd8,
        OP_PASS = 5'd9,
        OP_COM  = 5'd10,
        OP_NEG  = 5'd11,
        OP_INC  = 5'd12,
        OP_DEC  = 5'd13,
        OP_CLR  = 5'd14,
        OP_TST  = 5'd15,
        OP_ASL  = 5'd16,
        OP_ASR  = 5'd17,
        OP_LSR  = 5'd18,
        OP_ROL  = 5'd19,
        OP_ROR  = 5'd20
    } alu_op_e;

    localparam int OP_LAST = 20;

    typedef enum logic [1:0] {
        FA_KEEP,
        FA_CALC,
        FA_CLR,
        FA_SET
    } flag_act_e;

    typedef enum logic [2:0] {
        SRC_ARITH,
        SRC_LOGIC,
        SRC_SHIFT,
        SRC_OPA,
        SRC_OPB,
        SRC_ZERO,
        SRC_INV
    } val_src_e;

    typedef enum logic [1:0] {
        AO_A_B,
        AO_A_ONE,
        AO_ZERO_A
    } arith_opnd_e;

    typedef enum logic [1:0] {
        LOP_AND,
        LOP_OR,
        LOP_XOR
    } logic_op_e;

    typedef enum logic [2:0] {
        SH_ASL,
        SH_ASR,
        SH_LSR,
        SH_ROL,
        SH_ROR
    } shift_kind_e;

    typedef struct packed {
        val_src_e    res_src;
        val_src_e    nz_src;
        arith_opnd_e arith_opnd;
        logic        arith_sub;
        logic        arith_use_c;
        logic_op_e   logic_op;
        shift_kind_e shift_kind;
        logic        shift_flags;
        flag_act_e   h_act;
        flag_act_e   n_act;
        flag_act_e   z_act;
        flag_act_e   v_act;
        flag_act_e   c_act;
    } alu_ctrl_t;

endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
    import acc_alu_pkg::*;
(
    input  logic [OP_W-1:0] op_sel,
    output alu_ctrl_t       ctrl
);

    always_comb begin
        ctrl.res_src     = SRC_OPA;
        ctrl.nz_src      = SRC_OPA;
        ctrl.arith_opnd  = AO_A_B;
        ctrl.arith_sub   = 1'b0;
        ctrl.arith_use_c = 1'b0;
        ctrl.logic_op    = LOP_AND;
        ctrl.shift_kind  = SH_ASL;
        ctrl.shift_flags = 1'b0;
        ctrl.h_act       = FA_KEEP;
        ctrl.n_act       = FA_KEEP;
        ctrl.z_act       = FA_KEEP;
        ctrl.v_act       = FA_KEEP;
        ctrl.c_act       = FA_KEEP;

        unique case (op_sel)
            OP_ADD, OP_ADC: begin
                ctrl.res_src     = SRC_ARITH;
                ctrl.nz_src      = SRC_ARITH;
                ctrl.arith_use_c = (op_sel == OP_ADC);
                ctrl.h_act       = FA_CALC;
                ctrl.n_act       = FA_CALC;
                ctrl.z_act       = FA_CALC;
                ctrl.v_act       = FA_CALC;
                ctrl.c_act       = FA_CALC;
            end
            OP_SUB, OP_SBC, OP_CMP: begin
                ctrl.res_src     = (op_sel == OP_CMP) ? SRC_OPA : SRC_ARITH;
                ctrl.nz_src      = SRC_ARITH;
                ctrl.arith_sub   = 1'b1;
                ctrl.arith_use_c = (op_sel == OP_SBC);
                ctrl.n_act       = FA_CALC;
                ctrl.z_act       = FA_CALC;
                ctrl.v_act       = FA_CALC;
                ctrl.c_act       = FA_CALC;
            end
            OP_AND, OP_OR, OP_XOR, OP_BIT: begin
                ctrl.res_src  = (op_sel == OP_BIT) ? SRC_OPA : SRC_LOGIC;
                ctrl.nz_src   = SRC_LOGIC;
                ctrl.logic_op = (op_sel == OP_OR)  ? LOP_OR  :
                                (op_sel == OP_XOR) ? LOP_XOR : LOP_AND;
                ctrl.n_act    = FA_CALC;
                ctrl.z_act    = FA_CALC;
                ctrl.v_act    = FA_CLR;
            end
            OP_PASS: begin
                ctrl.res_src = SRC_OPB;
                ctrl.nz_src  = SRC_OPB;
                ctrl.n_act   = FA_CALC;
                ctrl.z_act   = FA_CALC;
                ctrl.v_act   = FA_CLR;
            end
            OP_COM: begin
                ctrl.res_src = SRC_INV;
                ctrl.nz_src  = SRC_INV;
                ctrl.n_act   = FA_CALC;
                ctrl.z_act   = FA_CALC;
                ctrl.v_act   = FA_CLR;
                ctrl.c_act   = FA_SET;
            end
            OP_NEG: begin
                ctrl.res_src    = SRC_ARITH;
                ctrl.nz_src     = SRC_ARITH;
                ctrl.arith_opnd = AO_ZERO_A;
                ctrl.arith_sub  = 1'b1;
                ctrl.n_act      = FA_CALC;
                ctrl.z_act      = FA_CALC;
                ctrl.v_act      = FA_CALC;
                ctrl.c_act      = FA_CALC;
            end
            OP_INC, OP_DEC: begin
                ctrl.res_src    = SRC_ARITH;
                ctrl.nz_src     = SRC_ARITH;
                ctrl.arith_opnd = AO_A_ONE;
                ctrl.arith_sub  = (op_sel == OP_DEC);
                ctrl.n_act      = FA_CALC;
                ctrl.z_act      = FA_CALC;
                ctrl.v_act      = FA_CALC;
            end
            OP_CLR: begin
                ctrl.res_src = SRC_ZERO;
                ctrl.nz_src  = SRC_ZERO;
                ctrl.n_act   = FA_CLR;
                ctrl.z_act   = FA_SET;
                ctrl.v_act   = FA_CLR;
                ctrl.c_act   = FA_CLR;
            end
            OP_TST: begin
                ctrl.n_act = FA_CALC;
                ctrl.z_act = FA_CALC;
                ctrl.v_act = FA_CLR;
                ctrl.c_act = FA_CLR;
            end
            OP_ASL, OP_ASR, OP_LSR, OP_ROL, OP_ROR: begin
                ctrl.res_src     = SRC_SHIFT;
                ctrl.nz_src      = SRC_SHIFT;
                ctrl.shift_flags = 1'b1;
                ctrl.shift_kind  = (op_sel == OP_ASL) ? SH_ASL :
                                   (op_sel == OP_ASR) ? SH_ASR :
                                   (op_sel == OP_LSR) ? SH_LSR :
                                   (op_sel == OP_ROL) ? SH_ROL : SH_ROR;
                ctrl.n_act       = (op_sel == OP_LSR) ? FA_CLR : FA_CALC;
                ctrl.z_act       = FA_CALC;
                ctrl.v_act       = FA_CALC;
                ctrl.c_act       = FA_CALC;
            end
            default: begin
                ctrl.res_src = SRC_OPA;
            end
        endcase
    end

endmodule

// File: rtl/acc_alu_arith.sv
module acc_alu_arith #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             sub,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             half,
    output logic             ovf
);

    localparam int MSB  = WIDTH - 1;
    localparam int HALF = WIDTH / 2;

    logic [WIDTH:0] wide;

    always_comb begin
        if (sub) begin
            wide = {1'b0, x} - {1'b0, y} - {{WIDTH{1'b0}}, cin};
        end else begin
            wide = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
        end
        sum  = wide[MSB:0];
        cout = wide[WIDTH];
        // carry into bit HALF equals the carry out of the lower half
        half = x[HALF] ^ y[HALF] ^ wide[HALF];
        if (sub) begin
            ovf = (x[MSB] != y[MSB]) && (wide[MSB] != x[MSB]);
        end else begin
            ovf = (x[MSB] == y[MSB]) && (wide[MSB] != x[MSB]);
        end
    end

endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift
    import acc_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] val,
    input  logic             cin,
    input  shift_kind_e      kind,
    output logic [WIDTH-1:0] res,
    output logic             cout
);

    localparam int MSB = WIDTH - 1;

    always_comb begin
        unique case (kind)
            SH_ASL: begin
                res  = {val[MSB-1:0], 1'b0};
                cout = val[MSB];
            end
            SH_ASR: begin
                res  = {val[MSB], val[MSB:1]};
                cout = val[0];
            end
            SH_LSR: begin
                res  = {1'b0, val[MSB:1]};
                cout = val[0];
            end
            SH_ROL: begin
                res  = {val[MSB-1:0], cin};
                cout = val[MSB];
            end
            SH_ROR: begin
                res  = {cin, val[MSB:1]};
                cout = val[0];
            end
            default: begin
                res  = val;
                cout = cin;
            end
        endcase
    end

endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags
    import acc_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [CC_W-1:0]  cc_in,
    input  logic [WIDTH-1:0] nz_val,
    input  logic             arith_h,
    input  logic             arith_v,
    input  logic             arith_c,
    input  logic             shift_c,
    input  logic             shift_flags,
    input  flag_act_e        h_act,
    input  flag_act_e        n_act,
    input  flag_act_e        z_act,
    input  flag_act_e        v_act,
    input  flag_act_e        c_act,
    output logic [CC_W-1:0]  cc_out
);

    function automatic logic resolve(input flag_act_e act, input logic old_v, input logic calc_v);
        unique case (act)
            FA_KEEP: resolve = old_v;
            FA_CALC: resolve = calc_v;
            FA_CLR:  resolve = 1'b0;
            FA_SET:  resolve = 1'b1;
            default: resolve = old_v;
        endcase
    endfunction

    logic c_new, n_new, z_new, v_new, h_new;

    always_comb begin
        c_new = resolve(c_act, cc_in[CC_C], shift_flags ? shift_c : arith_c);
        n_new = resolve(n_act, cc_in[CC_N], nz_val[WIDTH-1]);
        z_new = resolve(z_act, cc_in[CC_Z], nz_val == '0);
        v_new = resolve(v_act, cc_in[CC_V], shift_flags ? (n_new ^ c_new) : arith_v);
        h_new = resolve(h_act, cc_in[CC_H], arith_h);
    end

    generate
        for (genvar b = 0; b < CC_W; b++) begin : g_ccbit
            if (b == CC_C) begin : g_c
                assign cc_out[b] = c_new;
            end else if (b == CC_V) begin : g_v
                assign cc_out[b] = v_new;
            end else if (b == CC_Z) begin : g_z
                assign cc_out[b] = z_new;
            end else if (b == CC_N) begin : g_n
                assign cc_out[b] = n_new;
            end else if (b == CC_I) begin : g_i
                assign cc_out[b] = cc_in[b];
            end else if (b == CC_H) begin : g_h
                assign cc_out[b] = h_new;
            end else begin : g_one
                assign cc_out[b] = 1'b1;
            end
        end
    endgenerate

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [OP_W-1:0]  op_sel,
    input  logic [CC_W-1:0]  cc_in,
    output logic [WIDTH-1:0] result,
    output logic [CC_W-1:0]  cc_out
);

    localparam int MSB = WIDTH - 1;

    alu_ctrl_t        ctrl;
    logic [WIDTH-1:0] ar_x, ar_y, ar_sum, lg_val, sh_val, nz_val;
    logic             ar_cin, ar_c, ar_h, ar_v, sh_c;

    acc_alu_decode u_dec (
        .op_sel (op_sel),
        .ctrl   (ctrl)
    );

    always_comb begin
        unique case (ctrl.arith_opnd)
            AO_A_ONE: begin
                ar_x = opnd_a;
                ar_y = WIDTH'(1);
            end
            AO_ZERO_A: begin
                ar_x = '0;
                ar_y = opnd_a;
            end
            default: begin
                ar_x = opnd_a;
                ar_y = opnd_b;
            end
        endcase
        ar_cin = ctrl.arith_use_c & cc_in[CC_C];
    end

    acc_alu_arith #(.WIDTH(WIDTH)) u_arith (
        .x    (ar_x),
        .y    (ar_y),
        .sub  (ctrl.arith_sub),
        .cin  (ar_cin),
        .sum  (ar_sum),
        .cout (ar_c),
        .half (ar_h),
        .ovf  (ar_v)
    );

    always_comb begin
        unique case (ctrl.logic_op)
            LOP_OR:  lg_val = opnd_a | opnd_b;
            LOP_XOR: lg_val = opnd_a ^ opnd_b;
            default: lg_val = opnd_a & opnd_b;
        endcase
    end

    acc_alu_shift #(.WIDTH(WIDTH)) u_shift (
        .val  (opnd_a),
        .cin  (cc_in[CC_C]),
        .kind (ctrl.shift_kind),
        .res  (sh_val),
        .cout (sh_c)
    );

    function automatic logic [WIDTH-1:0] pick(
        input val_src_e         s,
        input logic [WIDTH-1:0] ar,
        input logic [WIDTH-1:0] lg,
        input logic [WIDTH-1:0] sh,
        input logic [WIDTH-1:0] a,
        input logic [WIDTH-1:0] b
    );
        unique case (s)
            SRC_ARITH: pick = ar;
            SRC_LOGIC: pick = lg;
            SRC_SHIFT: pick = sh;
            SRC_OPB:   pick = b;
            SRC_ZERO:  pick = '0;
            SRC_INV:   pick = ~a;
            default:   pick = a;
        endcase
    endfunction

    always_comb begin
        result = pick(ctrl.res_src, ar_sum, lg_val, sh_val, opnd_a, opnd_b);
        nz_val = pick(ctrl.nz_src,  ar_sum, lg_val, sh_val, opnd_a, opnd_b);
    end

    acc_alu_flags #(.WIDTH(WIDTH)) u_flags (
        .cc_in       (cc_in),
        .nz_val      (nz_val),
        .arith_h     (ar_h),
        .arith_v     (ar_v),
        .arith_c     (ar_c),
        .shift_c     (sh_c),
        .shift_flags (ctrl.shift_flags),
        .h_act       (ctrl.h_act),
        .n_act       (ctrl.n_act),
        .z_act       (ctrl.z_act),
        .v_act       (ctrl.v_act),
        .c_act       (ctrl.c_act),
        .cc_out      (cc_out)
    );

    // port-level checks of the flag rules
    always_comb begin
        assert_mask_kept_R1: assert (cc_out[CC_I] == cc_in[CC_I] && cc_out[7:6] == 2'b11)
            else $error("mask or spare bits disturbed");
        if (op_sel == OP_CLR) begin
            assert_clear_R5: assert (result == '0 && cc_out[3:0] == 4'b0100)
                else $error("clear result or flags wrong");
        end
        if (op_sel == OP_AND || op_sel == OP_OR || op_sel == OP_XOR ||
            op_sel == OP_BIT || op_sel == OP_PASS) begin
            assert_logic_keeps_c_R4: assert (cc_out[CC_C] == cc_in[CC_C] && !cc_out[CC_V]
                                             && cc_out[CC_H] == cc_in[CC_H])
                else $error("logic op touched C/H or left V set");
        end
        if (op_sel == OP_INC || op_sel == OP_DEC) begin
            assert_incdec_keeps_c_R7: assert (cc_out[CC_C] == cc_in[CC_C])
                else $error("inc/dec changed carry");
        end
        if (op_sel == OP_LSR) begin
            assert_lsr_flags_R10: assert (!result[MSB] && !cc_out[CC_N] && cc_out[CC_V] == cc_out[CC_C])
                else $error("logical shift right flags wrong");
        end
        if (op_sel == OP_ROL) begin
            assert_rol_carry_in_R11: assert (result[0] == cc_in[CC_C])
                else $error("rotate left lost old carry");
        end
        if (op_sel == OP_ROR) begin
            assert_ror_carry_in_R11: assert (result[MSB] == cc_in[CC_C])
                else $error("rotate right lost old carry");
        end
        if (op_sel > OP_W'(OP_LAST)) begin
            assert_reserved_noop_R12: assert (result == opnd_a && cc_out[5:0] == cc_in[5:0])
                else $error("reserved op code had an effect");
        end
    end

endmodule

// File: tb/acc_alu_test.sv
`timescale 1ns/1ps
module acc_alu_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] opnd_a = '0, opnd_b = '0, cc_in = '0;
    logic [4:0] op_sel = '0;
    logic [7:0] result, cc_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    acc_alu uut (
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .op_sel (op_sel),
        .cc_in  (cc_in),
        .result (result),
        .cc_out (cc_out)
    );

    // independent reference built from the requirement text
    function automatic logic [15:0] ref_alu(input int op, input int a, input int b, input logic [7:0] cci);
        logic h, i, n, z, v, c;
        int r, res, s, ci;
        bit nz_upd, keep_a;
        {h, i, n, z, v, c} = cci[5:0];
        r = a; nz_upd = 1; keep_a = 0;
        case (op)
            0, 1: begin
                ci = (op == 1) ? int'(c) : 0;
                s = a + b + ci; r = s & 255;
                h = ((a & 15) + (b & 15) + ci) > 15;
                c = s > 255;
                v = (((a ^ b) & 128) == 0) && (((a ^ r) & 128) != 0);
            end
            2, 3, 4: begin
                ci = (op == 3) ? int'(c) : 0;
                s = a - b - ci; r = s & 255;
                c = s < 0;
                v = (((a ^ b) & 128) != 0) && (((a ^ r) & 128) != 0);
                keep_a = (op == 4);
            end
            5: begin r = a & b; v = 0; end
            6: begin r = a | b; v = 0; end
            7: begin r = a ^ b; v = 0; end
            8: begin r = a & b; v = 0; keep_a = 1; end
            9: begin r = b; v = 0; end
            10: begin r = (~a) & 255; v = 0; c = 1; end
            11: begin r = (256 - a) & 255; c = (a != 0); v = (a == 128); end
            12: begin r = (a + 1) & 255; v = (a == 127); end
            13: begin r = (a + 255) & 255; v = (a == 128); end
            14: begin r = 0; v = 0; c = 0; end
            15: begin r = a; v = 0; c = 0; end
            16: begin r = (a << 1) & 255; c = a[7]; end
            17: begin r = (a >> 1) | (a & 128); c = a[0]; end
            18: begin r = a >> 1; c = a[0]; end
            19: begin r = ((a << 1) & 255) | int'(c); c = a[7]; end
            20: begin r = (a >> 1) | (int'(c) << 7); c = a[0]; end
            default: nz_upd = 0;
        endcase
        if (nz_upd) begin
            n = r[7];
            z = (r == 0);
        end
        if (op >= 16 && op <= 20) begin
            if (op == 18) n = 0;
            v = n ^ c;
        end
        res = (keep_a || !nz_upd) ? a : r;
        return {res[7:0], 2'b11, h, i, n, z, v, c};
    endfunction

    task automatic check(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] cc, input logic [15:0] exp, input string tag);
        @(negedge clk);
        op_sel = op; opnd_a = a; opnd_b = b; cc_in = cc;
        @(posedge clk);
        #1;
        n_checks++;
        if ({result, cc_out} !== exp) begin
            n_fail++;
            $display("FAIL %s op=%0d a=%h b=%h cc=%h: actual res=%h cc=%h, expected res=%h cc=%h",
                     tag, op, a, b, cc, result, cc_out, exp[15:8], exp[7:0]);
        end
    endtask

    task automatic check_m(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                           input logic [7:0] cc, input string tag);
        check(op, a, b, cc, ref_alu(int'(op), int'(a), int'(b), cc), tag);
    endtask

    task automatic t_reset_state;
        check(5'd0, 8'h00, 8'h00, 8'h00, {8'h00, 8'hC4}, "R1 reset state");
    endtask

    task automatic t_add;
        check(5'd0, 8'h08, 8'h08, 8'hC0, {8'h10, 8'hE0}, "R2 half carry");
        check(5'd0, 8'h7F, 8'h01, 8'hC0, {8'h80, 8'hEA}, "R2 overflow");
        check(5'd1, 8'hFF, 8'h00, 8'hC1, {8'h00, 8'hE5}, "R2 adc carry in");
        check_m(5'd1, 8'h80, 8'h80, 8'hC1, "R2 adc neg overflow");
    endtask

    task automatic t_sub;
        check(5'd2, 8'h00, 8'h01, 8'hC0, {8'hFF, 8'hC9}, "R3 borrow");
        check(5'd4, 8'h80, 8'h01, 8'hE0, {8'h80, 8'hE2}, "R3 compare keeps a");
        check_m(5'd3, 8'h10, 8'h0F, 8'hC1, "R3 sbc");
        check_m(5'd4, 8'h42, 8'h42, 8'hC0, "R3 compare equal");
    endtask

    task automatic t_logic;
        check(5'd5, 8'hF0, 8'h0F, 8'h23, {8'h00, 8'hE5}, "R4 and zero");
        check(5'd8, 8'h80, 8'hC0, 8'hC0, {8'h80, 8'hC8}, "R4 bit test keeps a");
        check(5'd9, 8'h55, 8'h00, 8'hCA, {8'h00, 8'hC4}, "R4 pass");
        check_m(5'd6, 8'h12, 8'h84, 8'hC3, "R4 or");
        check_m(5'd7, 8'hAA, 8'hAA, 8'hC2, "R4 xor");
    endtask

    task automatic t_clear;
        check(5'd14, 8'h9C, 8'h33, 8'hFF, {8'h00, 8'hF4}, "R5 clear");
    endtask

    task automatic t_com_neg;
        check(5'd10, 8'h00, 8'h00, 8'hC0, {8'hFF, 8'hC9}, "R6 complement");
        check(5'd11, 8'h80, 8'h00, 8'hC0, {8'h80, 8'hCB}, "R6 negate 0x80");
        check(5'd11, 8'h00, 8'h00, 8'hC1, {8'h00, 8'hC4}, "R6 negate zero");
        check_m(5'd11, 8'h01, 8'h00, 8'hC0, "R6 negate one");
    endtask

    task automatic t_incdec;
        check(5'd12, 8'h7F, 8'h00, 8'hC1, {8'h80, 8'hCB}, "R7 increment overflow");
        check(5'd13, 8'h00, 8'h00, 8'hC0, {8'hFF, 8'hC8}, "R7 decrement wrap");
        check_m(5'd13, 8'h80, 8'h00, 8'hC1, "R7 decrement overflow");
        check_m(5'd12, 8'hFF, 8'h00, 8'hC0, "R7 increment to zero");
    endtask

    task automatic t_test;
        check(5'd15, 8'h80, 8'h00, 8'hC3, {8'h80, 8'hC8}, "R8 test");
        check_m(5'd15, 8'h00, 8'h00, 8'hCB, "R8 test zero");
    endtask

    task automatic t_shifts;
        check(5'd17, 8'h81, 8'h00, 8'hC0, {8'hC0, 8'hC9}, "R9 asr");
        check(5'd16, 8'h40, 8'h00, 8'hC0, {8'h80, 8'hCA}, "R9 asl");
        check_m(5'd16, 8'h80, 8'h00, 8'hC0, "R9 asl to zero");
    endtask

    task automatic t_lsr;
        check(5'd18, 8'h01, 8'h00, 8'hC8, {8'h00, 8'hC7}, "R10 lsr");
        check_m(5'd18, 8'hFE, 8'h00, 8'hC1, "R10 lsr even");
    endtask

    task automatic t_rotate;
        check(5'd19, 8'h80, 8'h00, 8'hC1, {8'h01, 8'hC3}, "R11 rol");
        check(5'd20, 8'h01, 8'h00, 8'hC1, {8'h80, 8'hC9}, "R11 ror");
        check_m(5'd20, 8'h02, 8'h00, 8'hC0, "R11 ror no carry");
    endtask

    task automatic t_reserved;
        check(5'd25, 8'h5A, 8'hA5, 8'h3F, {8'h5A, 8'hFF}, "R12 reserved");
        check(5'd31, 8'h00, 8'hFF, 8'h00, {8'h00, 8'hC0}, "R12 reserved top");
    endtask

    task automatic t_sweep;
        logic [7:0] pat [8];
        pat[0] = 8'h00; pat[1] = 8'h7F; pat[2] = 8'h80; pat[3] = 8'hFF;
        pat[4] = 8'h01; pat[5] = 8'h0F; pat[6] = 8'hA5; pat[7] = 8'h5C;
        for (int op = 0; op < 32; op++) begin
            for (int k = 0; k < 8; k++) begin
                check_m(5'(op), pat[k], pat[(k + 3) % 8], (k % 2 == 0) ? 8'hD1 : 8'h2E,
                        "R1 sweep (mask and all ops)");
            end
        end
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_add();
        t_sub();
        t_logic();
        t_clear();
        t_com_neg();
        t_incdec();
        t_test();
        t_shifts();
        t_lsr();
        t_rotate();
        t_reserved();
        t_sweep();
        finish_run();
    end

endmodule